// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one video format. A pixel counter walks each line up to a programmed line length. A line counter steps once per line and covers a whole frame. From these positions the block drives a horizontal sync, a vertical sync and an active-picture flag. The sync delays, widths and polarities are all programmable. The vertical sync has a separate delay and width for each field of an interlaced frame.

After reset the generator stays idle with both counts at zero. It waits for a field-detection stage upstream to report the first field of a frame. That stage supplies a field flag together with a capture strobe, and the strobe marks the start of a vertical sync period. Once the generator is running, it free-runs until the next reset. It does not re-align to later strobes.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain control or status signal, and there is no back-pressure. The configuration inputs must be held steady while the generator runs. All outputs are registered.

Top module: `rtg_top`

## Requirements
- R1: After reset, and for as long as the generator is not running, `running_o` is 0, both counts are 0, `active_o` is 0, and each sync sits at its inactive level. The inactive level is 0 when its polarity bit is 1 (active-high) and 1 when the polarity bit is 0.
- R2: The generator starts on the first clock edge that samples `fid_stb`=1 with `fid_in`=0, where 0 means field 1. On that same edge the outputs take the values for pixel 0, line 0. A strobe with `fid_in`=1 does not start it.
- R3: While running, `pix_cnt` steps by one each clock from 0 to `cfg_line_total`-1, then returns to 0.
- R4: `line_cnt` advances by one when `pix_cnt` wraps, and returns to 0 after line `cfg_frame_lines`-1.
- R5: A line belongs to field 2 only when `cfg_interlace`=1 and `line_cnt` >= `cfg_field_lines`. The field-relative line number is `line_cnt` minus `cfg_field_lines` in field 2, and `line_cnt` itself in field 1. In progressive mode every line is field 1.
- R6: `hsync_o` is active while `pix_cnt` lies in [`cfg_hs_delay`, `cfg_hs_delay`+`cfg_hs_width`). Its active level is set by `cfg_hs_pol`.
- R7: `vsync_o` is active while the field-relative line lies in [delay, delay+width). The delay and width come from the settings of the current field. Its active level is set by `cfg_vs_pol`.
- R8: `active_o` is 1 only when all three of these hold: the generator is running, `pix_cnt` is outside [`cfg_hblank_pos`, `cfg_hblank_pos`+`cfg_hblank_len`), and the field-relative line is outside [`cfg_vblank_pos`, `cfg_vblank_pos`+`cfg_vblank_len`).
- R9: Once running, further strobes have no effect on the counts or outputs, whatever their field flag. The generator runs until reset.
- R10: The sync and active outputs describe the same position shown on `pix_cnt`/`line_cnt` in the same cycle, with no skew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_line_total | input | PW | Pixels per line (at least 2) |
| cfg_field_lines | input | LW | Lines in field 1 |
| cfg_frame_lines | input | LW | Lines per frame, both fields together |
| cfg_interlace | input | 1 | 1 = interlaced, 0 = progressive |
| cfg_hs_delay | input | PW | Horizontal sync start pixel |
| cfg_hs_width | input | PW | Horizontal sync width in pixels |
| cfg_hs_pol | input | 1 | Horizontal sync active level |
| cfg_vs_delay_f1 | input | LW | Field 1 vertical sync start line |
| cfg_vs_width_f1 | input | LW | Field 1 vertical sync width in lines |
| cfg_vs_delay_f2 | input | LW | Field 2 vertical sync start line |
| cfg_vs_width_f2 | input | LW | Field 2 vertical sync width in lines |
| cfg_vs_pol | input | 1 | Vertical sync active level |
| cfg_hblank_pos | input | PW | Horizontal blanking start pixel |
| cfg_hblank_len | input | PW | Horizontal blanking width |
| cfg_vblank_pos | input | LW | Vertical blanking start (field-relative line) |
| cfg_vblank_len | input | LW | Vertical blanking height in lines |
| fid_in | input | 1 | Field flag, 0 = field 1 |
| fid_stb | input | 1 | Field flag capture strobe |
| pix_cnt | output | PW | Current pixel |
| line_cnt | output | LW | Current frame line |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| active_o | output | 1 | Active picture flag |
| running_o | output | 1 | Generator running |

## Verification
A wrong pixel-counter state shows on `pix_cnt` within one clock, and every later sync and active value then slips with it. A broken line wrap or field selection shows up later, once per line or once per field. It appears as a vertical sync placed on the wrong lines of the second field, no later than one frame after start. A faulty start gate shows at `running_o` and the counts on the edge right after the offending strobe.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int SPAN_W = 16;

  // half-open span test, widened one bit so start+len never wraps
  function automatic logic in_span(input logic [SPAN_W-1:0] pos,
                                   input logic [SPAN_W-1:0] start,
                                   input logic [SPAN_W-1:0] len);
    logic [SPAN_W:0] p, s, e;
    p = {1'b0, pos};
    s = {1'b0, start};
    e = s + {1'b0, len};
    return (p >= s) && (p < e);
  endfunction
endpackage

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int PW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] line_total,
  input  logic [LW-1:0] frame_lines,
  input  logic          fid_in,
  input  logic          fid_stb,
  output logic          run_q,
  output logic [PW-1:0] pix_q,
  output logic [LW-1:0] line_q,
  output logic          run_d,
  output logic [PW-1:0] pix_d,
  output logic [LW-1:0] line_d
);
  logic start, pix_end, line_end;

  assign start    = !run_q && fid_stb && !fid_in;
  assign pix_end  = (pix_q == line_total - PW'(1));
  assign line_end = (line_q == frame_lines - LW'(1));

  always_comb begin
    run_d  = run_q | start;
    pix_d  = '0;
    line_d = '0;
    if (run_q) begin
      pix_d  = pix_end ? '0 : pix_q + PW'(1);
      line_d = line_q;
      if (pix_end) line_d = line_end ? '0 : line_q + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      run_q  <= run_d;
      pix_q  <= pix_d;
      line_q <= line_d;
    end
  end
endmodule

// File: rtl/rtg_field.sv
module rtg_field #(
  parameter int LW = 11
) (
  input  logic          interlace,
  input  logic [LW-1:0] field_lines,
  input  logic [LW-1:0] line,
  output logic          second,
  output logic [LW-1:0] fline
);
  assign second = interlace && (line >= field_lines);
  assign fline  = second ? line - field_lines : line;
endmodule

// File: rtl/rtg_sync.sv
module rtg_sync #(
  parameter int PW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_d,
  input  logic [PW-1:0] pix_d,
  input  logic [LW-1:0] fline_d,
  input  logic          second_d,
  input  logic [PW-1:0] hs_delay,
  input  logic [PW-1:0] hs_width,
  input  logic          hs_pol,
  input  logic [LW-1:0] vs_delay_f1,
  input  logic [LW-1:0] vs_width_f1,
  input  logic [LW-1:0] vs_delay_f2,
  input  logic [LW-1:0] vs_width_f2,
  input  logic          vs_pol,
  output logic          hs_q,
  output logic          vs_q
);
  import rtg_pkg::*;

  logic          hs_on, vs_on;
  logic [LW-1:0] vd, vw;

  assign vd    = second_d ? vs_delay_f2 : vs_delay_f1;
  assign vw    = second_d ? vs_width_f2 : vs_width_f1;
  assign hs_on = run_d && in_span(SPAN_W'(pix_d), SPAN_W'(hs_delay), SPAN_W'(hs_width));
  assign vs_on = run_d && in_span(SPAN_W'(fline_d), SPAN_W'(vd), SPAN_W'(vw));

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= ~hs_pol;
      vs_q <= ~vs_pol;
    end else begin
      hs_q <= hs_pol ? hs_on : ~hs_on;
      vs_q <= vs_pol ? vs_on : ~vs_on;
    end
  end
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int PW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_d,
  input  logic [PW-1:0] pix_d,
  input  logic [LW-1:0] fline_d,
  input  logic [PW-1:0] hb_pos,
  input  logic [PW-1:0] hb_len,
  input  logic [LW-1:0] vb_pos,
  input  logic [LW-1:0] vb_len,
  output logic          act_q
);
  import rtg_pkg::*;

  logic hblank, vblank;

  assign hblank = in_span(SPAN_W'(pix_d), SPAN_W'(hb_pos), SPAN_W'(hb_len));
  assign vblank = in_span(SPAN_W'(fline_d), SPAN_W'(vb_pos), SPAN_W'(vb_len));

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= run_d && !hblank && !vblank;
  end
endmodule

// File: rtl/rtg_top.sv
module rtg_top #(
  parameter int PW = 12,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] cfg_line_total,
  input  logic [LW-1:0] cfg_field_lines,
  input  logic [LW-1:0] cfg_frame_lines,
  input  logic          cfg_interlace,
  input  logic [PW-1:0] cfg_hs_delay,
  input  logic [PW-1:0] cfg_hs_width,
  input  logic          cfg_hs_pol,
  input  logic [LW-1:0] cfg_vs_delay_f1,
  input  logic [LW-1:0] cfg_vs_width_f1,
  input  logic [LW-1:0] cfg_vs_delay_f2,
  input  logic [LW-1:0] cfg_vs_width_f2,
  input  logic          cfg_vs_pol,
  input  logic [PW-1:0] cfg_hblank_pos,
  input  logic [PW-1:0] cfg_hblank_len,
  input  logic [LW-1:0] cfg_vblank_pos,
  input  logic [LW-1:0] cfg_vblank_len,
  input  logic          fid_in,
  input  logic          fid_stb,
  output logic [PW-1:0] pix_cnt,
  output logic [LW-1:0] line_cnt,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          active_o,
  output logic          running_o
);
  logic          run_d, second_d;
  logic [PW-1:0] pix_d;
  logic [LW-1:0] line_d, fline_d;

  rtg_counters #(.PW(PW), .LW(LW)) u_cnt (
    .clk(clk), .rst(rst),
    .line_total(cfg_line_total), .frame_lines(cfg_frame_lines),
    .fid_in(fid_in), .fid_stb(fid_stb),
    .run_q(running_o), .pix_q(pix_cnt), .line_q(line_cnt),
    .run_d(run_d), .pix_d(pix_d), .line_d(line_d)
  );

  rtg_field #(.LW(LW)) u_fld (
    .interlace(cfg_interlace), .field_lines(cfg_field_lines),
    .line(line_d), .second(second_d), .fline(fline_d)
  );

  rtg_sync #(.PW(PW), .LW(LW)) u_sync (
    .clk(clk), .rst(rst), .run_d(run_d), .pix_d(pix_d),
    .fline_d(fline_d), .second_d(second_d),
    .hs_delay(cfg_hs_delay), .hs_width(cfg_hs_width), .hs_pol(cfg_hs_pol),
    .vs_delay_f1(cfg_vs_delay_f1), .vs_width_f1(cfg_vs_width_f1),
    .vs_delay_f2(cfg_vs_delay_f2), .vs_width_f2(cfg_vs_width_f2),
    .vs_pol(cfg_vs_pol), .hs_q(hsync_o), .vs_q(vsync_o)
  );

  rtg_window #(.PW(PW), .LW(LW)) u_win (
    .clk(clk), .rst(rst), .run_d(run_d), .pix_d(pix_d), .fline_d(fline_d),
    .hb_pos(cfg_hblank_pos), .hb_len(cfg_hblank_len),
    .vb_pos(cfg_vblank_pos), .vb_len(cfg_vblank_len), .act_q(active_o)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int PW = 12,
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] cfg_line_total,
  input logic [LW-1:0] cfg_frame_lines,
  input logic          cfg_hs_pol,
  input logic          cfg_vs_pol,
  input logic          fid_in,
  input logic          fid_stb,
  input logic [PW-1:0] pix_cnt,
  input logic [LW-1:0] line_cnt,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          active_o,
  input logic          running_o
);
  // R1: idle keeps counts at zero and picture off
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !running_o |-> (pix_cnt == '0 && line_cnt == '0 && !active_o));

  // R1: idle keeps both syncs inactive
  a_r1_idle_sync: assert property (@(posedge clk) disable iff (rst)
    !running_o |-> (hsync_o != cfg_hs_pol && vsync_o != cfg_vs_pol));

  // R2: no start without a field-1 strobe
  a_r2_start_gate: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !(fid_stb && !fid_in)) |=> !running_o);

  // R3: pixel counter wraps at the line end
  a_r3_pix_wrap: assert property (@(posedge clk) disable iff (rst)
    (running_o && pix_cnt == cfg_line_total - PW'(1)) |=> pix_cnt == '0);

  // R3: pixel counter steps by one inside the line
  a_r3_pix_step: assert property (@(posedge clk) disable iff (rst)
    (running_o && pix_cnt != cfg_line_total - PW'(1)) |=> pix_cnt == $past(pix_cnt) + PW'(1));

  // R4: line holds inside a line
  a_r4_line_hold: assert property (@(posedge clk) disable iff (rst)
    (running_o && pix_cnt != cfg_line_total - PW'(1)) |=> $stable(line_cnt));

  // R4: frame wrap
  a_r4_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (running_o && pix_cnt == cfg_line_total - PW'(1) && line_cnt == cfg_frame_lines - LW'(1))
    |=> line_cnt == '0);

  // R9: running is sticky
  a_r9_run_sticky: assert property (@(posedge clk) disable iff (rst)
    running_o |=> running_o);
endmodule

bind rtg_top rtg_checker #(.PW(PW), .LW(LW)) u_chk (.*);

// File: tb/tb_rtg_top.sv
module tb_rtg_top;
  localparam int PW = 12;
  localparam int LW = 11;

  typedef struct packed {
    logic [15:0] ht, hsd, hsw; logic hp;
    logic [15:0] fl, fr; logic il;
    logic [15:0] vd1, vw1, vd2, vw2; logic vp;
    logic [15:0] hbp, hbl, vbp, vbl;
  } vec_t;

  // progressive; interlaced with active-low syncs; interlaced with hsync ending at wrap
  localparam vec_t VEC [3] = '{
    '{16'd12, 16'd1, 16'd3, 1'b1, 16'd9, 16'd9, 1'b0,
      16'd1, 16'd2, 16'd0, 16'd0, 1'b1, 16'd8, 16'd4, 16'd0, 16'd2},
    '{16'd10, 16'd0, 16'd2, 1'b0, 16'd5, 16'd11, 1'b1,
      16'd0, 16'd2, 16'd1, 16'd3, 1'b0, 16'd0, 16'd3, 16'd4, 16'd1},
    '{16'd16, 16'd14, 16'd2, 1'b1, 16'd6, 16'd12, 1'b1,
      16'd5, 16'd1, 16'd0, 16'd1, 1'b1, 16'd12, 16'd4, 16'd0, 16'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] cfg_line_total, cfg_hs_delay, cfg_hs_width, cfg_hblank_pos, cfg_hblank_len;
  logic [LW-1:0] cfg_field_lines, cfg_frame_lines, cfg_vs_delay_f1, cfg_vs_width_f1;
  logic [LW-1:0] cfg_vs_delay_f2, cfg_vs_width_f2, cfg_vblank_pos, cfg_vblank_len;
  logic cfg_interlace, cfg_hs_pol, cfg_vs_pol;
  logic fid_in = 1'b0, fid_stb = 1'b0;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;
  logic hsync_o, vsync_o, active_o, running_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtg_top #(.PW(PW), .LW(LW)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input vec_t v);
    cfg_line_total = PW'(v.ht);  cfg_hs_delay = PW'(v.hsd); cfg_hs_width = PW'(v.hsw);
    cfg_hs_pol = v.hp;           cfg_field_lines = LW'(v.fl); cfg_frame_lines = LW'(v.fr);
    cfg_interlace = v.il;        cfg_vs_delay_f1 = LW'(v.vd1); cfg_vs_width_f1 = LW'(v.vw1);
    cfg_vs_delay_f2 = LW'(v.vd2); cfg_vs_width_f2 = LW'(v.vw2); cfg_vs_pol = v.vp;
    cfg_hblank_pos = PW'(v.hbp); cfg_hblank_len = PW'(v.hbl);
    cfg_vblank_pos = LW'(v.vbp); cfg_vblank_len = LW'(v.vbl);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_idle(input vec_t v, input string tag);
    check({tag, " R1 running"}, int'(running_o), 0);
    check({tag, " R1 pix"}, int'(pix_cnt), 0);
    check({tag, " R1 line"}, int'(line_cnt), 0);
    check({tag, " R1 active"}, int'(active_o), 0);
    check({tag, " R1 hsync idle"}, int'(hsync_o), int'(!v.hp));
    check({tag, " R1 vsync idle"}, int'(vsync_o), int'(!v.vp));
  endtask

  function automatic bit span(input int p, input int s, input int l);
    return (p >= s) && (p < s + l);
  endfunction

  initial begin
    vec_t v;
    int ep, el, fl, cyc;
    bit f2;
    load(VEC[0]);
    for (int i = 0; i < 3; i++) begin
      v = VEC[i];
      load(v);
      do_reset();
      check_idle(v, "reset");
      // R2: a field-2 strobe must not start the generator
      fid_in = 1'b1; fid_stb = 1'b1;
      @(negedge clk);
      fid_stb = 1'b0;
      @(negedge clk);
      check_idle(v, "R2 field2 strobe");
      // R2: field-1 strobe starts it at position (0,0)
      fid_in = 1'b0; fid_stb = 1'b1;
      @(negedge clk);
      fid_stb = 1'b0;
      ep = 0; el = 0;
      cyc = 2 * int'(v.fr) * int'(v.ht);
      for (int k = 0; k < cyc; k++) begin
        f2 = v.il && (el >= int'(v.fl));
        fl = f2 ? el - int'(v.fl) : el;
        check("R2/R9 running", int'(running_o), 1);
        check("R3 pix", int'(pix_cnt), ep);
        check("R4 line", int'(line_cnt), el);
        check("R6/R10 hsync", int'(hsync_o),
              int'(span(ep, int'(v.hsd), int'(v.hsw)) ? v.hp : !v.hp));
        check("R5/R7 vsync", int'(vsync_o),
              int'(span(fl, f2 ? int'(v.vd2) : int'(v.vd1), f2 ? int'(v.vw2) : int'(v.vw1))
                   ? v.vp : !v.vp));
        check("R8 active", int'(active_o),
              int'(!span(ep, int'(v.hbp), int'(v.hbl)) && !span(fl, int'(v.vbp), int'(v.vbl))));
        // R9: extra strobes of either field while running are ignored
        fid_stb = (k == 7) || (k == 23);
        fid_in  = (k == 23);
        if (ep == int'(v.ht) - 1) begin
          ep = 0;
          el = (el == int'(v.fr) - 1) ? 0 : el + 1;
        end else ep++;
        @(negedge clk);
      end
      fid_stb = 1'b0; fid_in = 1'b0;
    end
    // directed: reset mid-run returns to idle (R1)
    check("R9 still running before reset", int'(running_o), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_idle(VEC[2], "R1 mid-run reset");
    // directed: idle hold-off with no strobe (R2)
    repeat (20) @(negedge clk);
    check_idle(VEC[2], "R2 hold-off");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule